// File: doc/BRIEF.md
# In-Order Completion Queue with Interrupt Gating

This block tracks dispatched instructions from dispatch until they retire, and decides when an external interrupt may be taken. Dispatch places each instruction into a small circular queue, but only when a slot is free. The block numbers each instruction with a program-order tag and reports the slot it used. Execution units report completion for any slot in any order. The oldest entry (the head) retires only after it has finished, one entry per cycle, so results always commit in program order.

Stores are never released to memory before they retire. A retiring store moves into a one-entry committed-store holding register. That register requests memory access and empties once access is granted. When an enabled interrupt is pending, exactly one instruction may still leave the queue: the current head, which either retires or raises its own exception. After that, retirement freezes. The interrupt is then accepted once the store holder is empty, or in the same cycle its access is granted. Accepting the interrupt, or a head exception, discards every entry that has not retired. The block then reports the tag where execution resumes, and dispatch numbering restarts from that tag.

Top module: `cq_completion`

## Requirements
- R1: The head entry retires only after it has finished, at most one entry per cycle. `retireValid` is high in the cycle after the head's finish report is registered. Retired tags are strictly consecutive in dispatch order, whatever order the finish reports arrive in.
- R2: `dispReady` is low while all 5 slots are held. Each accepted dispatch is given the next tag (8-bit, wrapping) and the next slot index 0..4 in circular order. After reset, `dispTag` is 0, the first slot is 0, the queue is empty and `dispReady` is high.
- R3: A retiring store enters the store holder, which shows `storeReq` high and `storeTag` from the next cycle on. A finished store at the head stalls while the holder is full. It retires in the same cycle `storeGrant` empties the holder.
- R4: While `intPending` and `intEnable` are both high, at most one instruction (the head) retires or raises an exception. After that, no further retirement occurs until the interrupt is taken or the request drops.
- R5: A finished head that reported an exception (`finExc`=1) pulses `excTake` and is never retired. `resumeTag` equals the faulting tag, and every entry is flushed. This happens before any pending interrupt is accepted.
- R6: `takeInt` pulses only when the store holder is empty, or when `storeGrant` is high in that same cycle.
- R7: With `intEnable` low, `intPending` has no effect: no `takeInt`, and retirement proceeds normally.
- R8: On `takeInt`, all non-retired entries are flushed. `resumeTag` is the oldest non-retired tag, or the next dispatch tag if the queue is empty. The next dispatch reuses that tag in slot 0.
- R9: A finish report for a slot that holds no instruction is ignored. A later dispatch into that slot is not treated as finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispValid | input | 1 | Dispatch request |
| dispStore | input | 1 | Dispatched instruction is a store |
| dispReady | output | 1 | A slot is free and no flush is occurring |
| dispSlot | output | 3 | Slot the dispatched instruction will occupy |
| dispTag | output | 8 | Tag the dispatched instruction will receive |
| finValid | input | 1 | Execution finish report |
| finSlot | input | 3 | Slot being reported finished |
| finExc | input | 1 | Finished instruction raised an exception |
| intPending | input | 1 | External interrupt request |
| intEnable | input | 1 | External interrupt enable |
| storeGrant | input | 1 | Memory access for the held store starts this cycle |
| retireValid | output | 1 | Head retires this cycle |
| retireTag | output | 8 | Tag of the retiring head |
| excTake | output | 1 | Head exception taken this cycle |
| takeInt | output | 1 | External interrupt accepted this cycle |
| resumeTag | output | 8 | Tag of the oldest non-retired instruction |
| storeReq | output | 1 | Store holder occupied, requesting access |
| storeTag | output | 8 | Tag of the held store |

## Verification
The assertions assume the environment behaves like a real pipeline. Each slot is reported finished at most once per occupancy. No finish report names a slot that is being dispatched into in the same cycle. `storeGrant` is raised only while `storeReq` is high. The request or its enable drops in the cycle after `takeInt`, as a handler entry would clear the enable.

The stimulus keeps within these limits. It issues finish reports only for slots it has recorded from `dispSlot`, and grants stores only after it has seen `storeReq`. It lowers the interrupt inputs right after each accepted interrupt. The finish-order sweep rotates and reverses the report order over full queues.

// File: rtl/cq_pkg.sv
package cq_pkg;
  typedef struct packed {
    logic alloc;
    logic retire;
    logic except;
    logic take;
  } cqStrobe_t;

  typedef struct packed {
    logic headValid;
    logic headDone;
    logic headExc;
    logic headStore;
    logic empty;
    logic full;
    logic sbFull;
  } cqStatus_t;
endpackage

// File: rtl/cq_datapath.sv
module cq_datapath
  import cq_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int TAG_W = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  cqStrobe_t        strb,
  input  logic             dispStore,
  input  logic             finValid,
  input  logic [IDX_W-1:0] finSlot,
  input  logic             finExc,
  input  logic             storeGrant,
  output cqStatus_t        status,
  output logic [IDX_W-1:0] tailIdx,
  output logic [TAG_W-1:0] nextTag,
  output logic [TAG_W-1:0] headTag,
  output logic [TAG_W-1:0] resumeTag,
  output logic             sbFull,
  output logic [TAG_W-1:0] sbTag
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [DEPTH-1:0] validQ, doneQ, excQ, storeQ;
  logic [TAG_W-1:0] tagQ [DEPTH];
  logic [IDX_W-1:0] headPtr, tailPtr;
  logic [CNT_W-1:0] countQ;
  logic [TAG_W-1:0] nextTagQ;
  logic             flush;

  function automatic logic [IDX_W-1:0] ptrInc(input logic [IDX_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign flush     = strb.except | strb.take;
  assign headTag   = tagQ[headPtr];
  assign resumeTag = status.empty ? nextTagQ : headTag;
  assign nextTag   = nextTagQ;
  assign tailIdx   = tailPtr;

  always_comb begin
    status.headValid = validQ[headPtr];
    status.headDone  = doneQ[headPtr];
    status.headExc   = excQ[headPtr];
    status.headStore = storeQ[headPtr];
    status.empty     = (countQ == '0);
    status.full      = (countQ == CNT_W'(DEPTH));
    status.sbFull    = sbFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      doneQ  <= '0;
      excQ   <= '0;
      storeQ <= '0;
      for (int i = 0; i < DEPTH; i++) tagQ[i] <= '0;
    end else if (flush) begin
      validQ <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (strb.retire && headPtr == IDX_W'(i)) validQ[i] <= 1'b0;
        if (finValid && finSlot == IDX_W'(i) && validQ[i]) begin
          doneQ[i] <= 1'b1;
          excQ[i]  <= finExc;
        end
        if (strb.alloc && tailPtr == IDX_W'(i)) begin
          validQ[i] <= 1'b1;
          doneQ[i]  <= 1'b0;
          excQ[i]   <= 1'b0;
          storeQ[i] <= dispStore;
          tagQ[i]   <= nextTagQ;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr  <= '0;
      tailPtr  <= '0;
      countQ   <= '0;
      nextTagQ <= '0;
    end else if (flush) begin
      headPtr  <= '0;
      tailPtr  <= '0;
      countQ   <= '0;
      nextTagQ <= resumeTag;
    end else begin
      if (strb.retire) headPtr <= ptrInc(headPtr);
      if (strb.alloc) begin
        tailPtr  <= ptrInc(tailPtr);
        nextTagQ <= nextTagQ + 1'b1;
      end
      countQ <= countQ + CNT_W'(strb.alloc) - CNT_W'(strb.retire);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sbFull <= 1'b0;
      sbTag  <= '0;
    end else if (strb.retire && status.headStore) begin
      sbFull <= 1'b1;
      sbTag  <= headTag;
    end else if (storeGrant) begin
      sbFull <= 1'b0;
    end
  end

  // Independent tracker of the tag expected at the next retirement.
  logic [TAG_W-1:0] expTagQ;
  always_ff @(posedge clk) begin
    if (!rstN) expTagQ <= '0;
    else if (flush) expTagQ <= resumeTag;
    else if (strb.retire) expTagQ <= expTagQ + 1'b1;
  end

  p_order_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.retire |-> (headTag == expTagQ));
  p_alloc_free_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.alloc |-> (countQ < CNT_W'(DEPTH)));
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= CNT_W'(DEPTH));
  p_store_stall_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.retire && status.headStore && sbFull) |-> storeGrant);
endmodule

// File: rtl/cq_control.sv
module cq_control
  import cq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  cqStatus_t status,
  input  logic      dispValid,
  input  logic      intPending,
  input  logic      intEnable,
  input  logic      storeGrant,
  output logic      dispReady,
  output cqStrobe_t strb
);
  logic intReq, oneRetired, allow, headReady, storeOk;

  assign intReq    = intPending & intEnable;
  assign allow     = ~intReq | ~oneRetired;
  assign headReady = allow & status.headValid & status.headDone;
  assign storeOk   = ~status.headStore | ~status.sbFull | storeGrant;

  always_comb begin
    strb.except = headReady & status.headExc;
    strb.retire = headReady & ~status.headExc & storeOk;
    strb.take   = intReq & (~status.sbFull | storeGrant) &
                  (status.empty | oneRetired);
    dispReady   = ~status.full & ~strb.take & ~strb.except;
    strb.alloc  = dispValid & dispReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) oneRetired <= 1'b0;
    else if (strb.take || !intReq) oneRetired <= 1'b0;
    else if (strb.retire || strb.except) oneRetired <= 1'b1;
  end

  p_take_enable_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |-> (intEnable && intPending));
endmodule

// File: rtl/cq_completion.sv
module cq_completion
  import cq_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int TAG_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dispValid,
  input  logic             dispStore,
  output logic             dispReady,
  output logic [IDX_W-1:0] dispSlot,
  output logic [TAG_W-1:0] dispTag,
  input  logic             finValid,
  input  logic [IDX_W-1:0] finSlot,
  input  logic             finExc,
  input  logic             intPending,
  input  logic             intEnable,
  input  logic             storeGrant,
  output logic             retireValid,
  output logic [TAG_W-1:0] retireTag,
  output logic             excTake,
  output logic             takeInt,
  output logic [TAG_W-1:0] resumeTag,
  output logic             storeReq,
  output logic [TAG_W-1:0] storeTag
);
  cqStrobe_t strb;
  cqStatus_t status;

  cq_control uCtrl (
    .clk(clk), .rstN(rstN), .status(status), .dispValid(dispValid),
    .intPending(intPending), .intEnable(intEnable), .storeGrant(storeGrant),
    .dispReady(dispReady), .strb(strb)
  );

  cq_datapath #(.DEPTH(DEPTH), .TAG_W(TAG_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .dispStore(dispStore),
    .finValid(finValid), .finSlot(finSlot), .finExc(finExc),
    .storeGrant(storeGrant), .status(status), .tailIdx(dispSlot),
    .nextTag(dispTag), .headTag(retireTag), .resumeTag(resumeTag),
    .sbFull(storeReq), .sbTag(storeTag)
  );

  assign retireValid = strb.retire;
  assign excTake     = strb.except;
  assign takeInt     = strb.take;

  p_single_head_r4: assert property (@(posedge clk) disable iff (!rstN)
    (intPending && intEnable && $past(intPending && intEnable) &&
     $past(retireValid || excTake)) |-> !(retireValid || excTake));
  p_flush_r5: assert property (@(posedge clk) disable iff (!rstN)
    (takeInt || excTake) |=> !(retireValid || excTake));
  p_take_drained_r6: assert property (@(posedge clk) disable iff (!rstN)
    takeInt |-> (!storeReq || storeGrant));
endmodule

// File: tb/cq_completion_test.sv
module cq_completion_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic dispValid = 0, dispStore = 0, finValid = 0, finExc = 0;
  logic intPending = 0, intEnable = 0, storeGrant = 0;
  logic [2:0] finSlot = '0;
  logic dispReady, retireValid, excTake, takeInt, storeReq;
  logic [2:0] dispSlot;
  logic [7:0] dispTag, retireTag, resumeTag, storeTag;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cq_completion uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic settle();
    #1;
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    int slots [5];
    int mdone [5];
    int mhead;
    int ord;
    repeat (3) cyc();
    rstN = 1'b1;
    settle();
    // reset state (R2)
    chk("R2 reset dispReady", dispReady, 1);
    chk("R2 reset dispTag", dispTag, 0);
    chk("R2 reset dispSlot", dispSlot, 0);
    chk("R3 reset storeReq", storeReq, 0);
    chk("R1 reset retireValid", retireValid, 0);

    // finish-order sweep (R1, R2)
    base = 0;
    for (int k = 0; k < 5; k++) begin
      for (int i = 0; i < 5; i++) begin
        dispValid = 1; settle();
        chk("R2 ready", dispReady, 1);
        chk("R2 tag", dispTag, (base + i) % 256);
        chk("R2 slot", dispSlot, i);
        slots[i] = dispSlot;
        mdone[i] = 0;
        cyc();
      end
      dispValid = 1; settle();
      chk("R2 full not ready", dispReady, 0);
      dispValid = 0;
      mhead = 0;
      for (int c = 0; c < 10; c++) begin
        ord = (k % 2 == 0) ? (c + k) % 5 : (k - c + 5) % 5;
        if (c < 5) begin finValid = 1; finSlot = 3'(slots[ord]); end
        else finValid = 0;
        settle();
        if (mhead < 5 && mdone[mhead] == 1) begin
          chk("R1 retire", retireValid, 1);
          chk("R1 retire tag", retireTag, (base + mhead) % 256);
          mhead++;
        end else chk("R1 hold", retireValid, 0);
        if (c < 5) mdone[ord] = 1;
        cyc();
      end
      chk("R1 all retired", mhead, 5);
      base += 5;
    end
    finValid = 0;

    // stores (R3): tags 25 and 26 in slots 0 and 1
    dispValid = 1; dispStore = 1; cyc();
    cyc();
    dispValid = 0; dispStore = 0;
    finValid = 1; finSlot = 0; cyc();
    finSlot = 1; settle();
    chk("R3 first store retires", retireValid, 1);
    chk("R3 first store tag", retireTag, 25);
    chk("R3 holder empty before", storeReq, 0);
    cyc();
    finValid = 0; settle();
    chk("R3 holder full", storeReq, 1);
    chk("R3 holder tag", storeTag, 25);
    chk("R3 stall", retireValid, 0);
    cyc();
    chk("R3 stall again", retireValid, 0);
    storeGrant = 1; settle();
    chk("R3 retire on grant", retireValid, 1);
    chk("R3 retire on grant tag", retireTag, 26);
    cyc();
    storeGrant = 0; settle();
    chk("R3 second store held", storeReq, 1);
    chk("R3 second store tag", storeTag, 26);

    // interrupt with one head and full holder (R4, R6, R8): tags 27 slot2, 28 slot3
    dispValid = 1; cyc();
    cyc();
    dispValid = 0;
    intPending = 1; intEnable = 1; finValid = 1; finSlot = 3; settle();
    chk("R4 no take with unfinished head", takeInt, 0);
    cyc();
    finSlot = 2; settle();
    chk("R4 no retire yet", retireValid, 0);
    cyc();
    finValid = 0; settle();
    chk("R4 head retires", retireValid, 1);
    chk("R4 head tag", retireTag, 27);
    chk("R6 no take yet", takeInt, 0);
    cyc();
    chk("R4 younger blocked", retireValid, 0);
    chk("R6 holder full blocks take", takeInt, 0);
    cyc();
    chk("R4 younger still blocked", retireValid, 0);
    chk("R6 still blocked", takeInt, 0);
    storeGrant = 1; settle();
    chk("R6 take on grant", takeInt, 1);
    chk("R8 resume oldest", resumeTag, 28);
    cyc();
    intPending = 0; intEnable = 0; storeGrant = 0; settle();
    chk("R8 tag restarts", dispTag, 28);
    chk("R8 slot restarts", dispSlot, 0);
    chk("R8 flushed", retireValid, 0);
    chk("R6 holder drained", storeReq, 0);

    // enable low (R7): tag 28 slot 0
    intPending = 1; dispValid = 1; settle();
    chk("R7 no take disabled", takeInt, 0);
    cyc();
    dispValid = 0; finValid = 1; finSlot = 0; settle();
    chk("R7 no take disabled 2", takeInt, 0);
    cyc();
    finValid = 0; settle();
    chk("R7 normal retire", retireValid, 1);
    chk("R7 normal retire tag", retireTag, 28);
    cyc();
    chk("R7 still no take", takeInt, 0);
    intEnable = 1; settle();
    chk("R8 take on empty", takeInt, 1);
    chk("R8 resume next tag", resumeTag, 29);
    cyc();
    intPending = 0; intEnable = 0;

    // head exception before interrupt (R5): tags 29 slot0, 30 slot1
    dispValid = 1; cyc();
    cyc();
    dispValid = 0;
    intPending = 1; intEnable = 1; finValid = 1; finSlot = 1; settle();
    chk("R5 no take pending head", takeInt, 0);
    cyc();
    finSlot = 0; finExc = 1; cyc();
    finValid = 0; finExc = 0; settle();
    chk("R5 exception taken", excTake, 1);
    chk("R5 resume faulting", resumeTag, 29);
    chk("R5 not retired", retireValid, 0);
    chk("R5 exception before interrupt", takeInt, 0);
    cyc();
    chk("R5 one exception", excTake, 0);
    chk("R5 interrupt after", takeInt, 1);
    chk("R5 resume after flush", resumeTag, 29);
    cyc();
    intPending = 0; intEnable = 0; settle();
    chk("R5 tag restarts", dispTag, 29);

    // finish to empty slot ignored (R9)
    finValid = 1; finSlot = 3; finExc = 1; cyc();
    finValid = 0; finExc = 0; finSlot = 0;
    dispValid = 1; settle();
    chk("R9 slot", dispSlot, 0);
    cyc();
    dispValid = 0;
    // probe slot 3 (4th dispatch) stays unfinished
    for (int i = 0; i < 3; i++) begin dispValid = 1; cyc(); end
    dispValid = 0; settle();
    chk("R9 no retire", retireValid, 0);
    chk("R9 no exception", excTake, 0);
    finValid = 1; finSlot = 0; cyc();
    finSlot = 1; settle();
    chk("R9 head retires", retireValid, 1);
    cyc();
    finSlot = 2; settle();
    chk("R9 second retires", retireValid, 1);
    cyc();
    finValid = 0; settle();
    chk("R9 third retires", retireValid, 1);
    cyc();
    chk("R9 ignored report left slot unfinished", retireValid, 0);
    chk("R9 no stale exception", excTake, 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule